// File: doc/BRIEF.md
# Lockable Flash Timing Clock Divider

This block holds the 8-bit control word that sets how far the bus clock is divided down to make the roughly 1 MHz timing tick used by flash program and erase timers. Beside the register sits the divider counter that turns the stored ratio into a tick enable one clock wide. The register packs a read-only "programmed" flag, a lock bit that can be set once, and a 6-bit divide value.

Software writes the register over a plain write strobe with byte data and can read it back at any time on a combinational read bus. A write is taken only while the flash command engine reports idle, or while the reset sequence is still running. Once the lock bit has been set, the divide value is frozen until the next reset. The tick stays low until the register has been programmed at least once.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset the read value is 0x00 and `tick` is low.
- R2: Read value layout: bit 7 is the programmed flag, bit 6 is the lock bit, bits 5..0 are the divide value. Bit 7 of the write data has no effect.
- R3: An accepted write sets the programmed flag to 1. It stays 1 until reset.
- R4: Writing 1 to bit 6 sets the lock bit. Writing 0 to bit 6 leaves it unchanged, and only reset clears it.
- R5: While the lock bit is 1, writes leave the divide value unchanged.
- R6: A write made while `cmd_idle` is 0 and `rst_seq_active` is 0 is dropped entirely. It leaves all three fields unchanged, including the programmed flag.
- R7: While `rst_seq_active` is 1, writes are accepted even when `cmd_idle` is 0.
- R8: A write that sets the lock bit also loads its divide value in that same write. The lock applies only to writes that come later.
- R9: With divide value D, `tick` is high for one cycle in every D+1 cycles. The first tick falls D cycles after the clock edge that took the write (every cycle when D=0).
- R10: A write that changes the divide value restarts the count, so the next tick comes D cycles after that write.
- R11: `tick` is low while the programmed flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| cmd_idle | input | 1 | High when no flash command is executing |
| rst_seq_active | input | 1 | High during the flash reset sequence |
| tick | output | 1 | Timing tick enable, one cycle wide |

## Verification
The hardest case to reach is a write made after a reset that is refused because a command is running. It must leave the programmed flag at 0 as well as leave the divide value alone. The bench reaches it by issuing that refused write as the very first access after a fresh reset, then reading back 0x00 and watching `tick` stay low. The counter restart is reached by rewriting the divide value partway through a count and timing the distance to the next tick.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  localparam int REG_W     = 8;
  localparam int DIV_W     = 6;
  localparam int BIT_PROG  = 7;
  localparam int BIT_LOCK  = 6;
endpackage

// File: rtl/ftd_ctrl_reg.sv
module ftd_ctrl_reg
  import ftd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cmd_idle,
  input  logic             rst_seq_active,
  output logic             prog_q,
  output logic             lock_q,
  output logic [DIV_W-1:0] div_q,
  output logic             restart
);
  logic accept;

  assign accept  = wr_en && (cmd_idle || rst_seq_active);
  assign restart = accept && !lock_q && (wr_data[DIV_W-1:0] != div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      lock_q <= 1'b0;
      div_q  <= '0;
    end else if (accept) begin
      prog_q <= 1'b1;
      lock_q <= lock_q | wr_data[BIT_LOCK];
      if (!lock_q) div_q <= wr_data[DIV_W-1:0];
    end
  end

  p_prog_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |=> prog_q);
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_div_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(div_q));
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cmd_idle && !rst_seq_active) |=> $stable({prog_q, lock_q, div_q}));
  p_rstseq_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rst_seq_active) |=> prog_q);
endmodule

// File: rtl/ftd_counter.sv
module ftd_counter
  import ftd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             restart,
  input  logic             enable,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == div_val);
  assign tick = enable && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart || wrap) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  p_tick_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tick);
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_val);
  p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider
  import ftd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             cmd_idle,
  input  logic             rst_seq_active,
  output logic             tick
);
  logic             prog_q;
  logic             lock_q;
  logic [DIV_W-1:0] div_q;
  logic             restart;

  ftd_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_idle(cmd_idle), .rst_seq_active(rst_seq_active),
    .prog_q(prog_q), .lock_q(lock_q), .div_q(div_q), .restart(restart)
  );

  ftd_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .div_val(div_q), .restart(restart),
    .enable(prog_q), .tick(tick)
  );

  always_comb begin
    rd_data = '0;
    rd_data[BIT_PROG]   = prog_q;
    rd_data[BIT_LOCK]   = lock_q;
    rd_data[DIV_W-1:0]  = div_q;
  end

  p_read_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> rd_data[BIT_LOCK] && rd_data[BIT_PROG]);
endmodule

// File: tb/tb_flash_tick_divider.sv
module tb_flash_tick_divider;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_idle = 1'b1;
  logic       rst_seq_active = 1'b0;
  logic [7:0] rd_data;
  logic       tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_tick_divider dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmd_idle(cmd_idle), .rst_seq_active(rst_seq_active),
    .tick(tick)
  );

  typedef struct packed {
    logic [7:0] wd;
    logic       idle;
    logic       rs;
    logic [7:0] exp;
  } vec_t;

  // Walked after a fresh reset, each entry is one write then a readback.
  localparam vec_t VECS [8] = '{
    '{8'h05, 1'b1, 1'b0, 8'h85},  // R3 accepted write sets programmed flag
    '{8'h0A, 1'b0, 1'b0, 8'h85},  // R6 busy write dropped
    '{8'h07, 1'b0, 1'b1, 8'h87},  // R7 reset-sequence write taken while busy
    '{8'h03, 1'b1, 1'b0, 8'h83},  // R2 bit 7 of data ignored (written 0 stays 1)
    '{8'h49, 1'b1, 1'b0, 8'hC9},  // R8 lock and divide loaded together
    '{8'h02, 1'b1, 1'b0, 8'hC9},  // R4 R5 writing 0 to lock, divide frozen
    '{8'h3F, 1'b0, 1'b1, 8'hC9},  // R5 locked even during reset sequence
    '{8'h80, 1'b1, 1'b0, 8'hC9}   // R2 R4 lock and divide unchanged
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cmd_idle = 1'b1; rst_seq_active = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drives at a negedge; returns at the next negedge, after the edge that takes the write.
  task automatic do_write(input logic [7:0] d, input logic idle, input logic rs);
    wr_en = 1'b1; wr_data = d; cmd_idle = idle; rst_seq_active = rs;
    @(negedge clk);
    wr_en = 1'b0; cmd_idle = 1'b1; rst_seq_active = 1'b0;
  endtask

  // Samples tick for n negedges; expects a tick where (k+1) % (d+1) == 0 after offset.
  task automatic tick_run(input string req, input int d, input int n);
    for (int k = 0; k < n; k++) begin
      check(req, {7'd0, tick}, {7'd0, ((k % (d + 1)) == d)});
      @(negedge clk);
    end
  endtask

  initial begin
    do_reset();
    check("R1 reset read", rd_data, 8'h00);
    for (int k = 0; k < 5; k++) begin
      check("R1 R11 tick low after reset", {7'd0, tick}, 8'h00);
      @(negedge clk);
    end

    for (int i = 0; i < 8; i++) begin
      do_write(VECS[i].wd, VECS[i].idle, VECS[i].rs);
      check("vector table", rd_data, VECS[i].exp);
    end

    // R6: refused write as first access leaves programmed flag clear.
    do_reset();
    do_write(8'h45, 1'b0, 1'b0);
    check("R6 dropped write keeps flag clear", rd_data, 8'h00);
    for (int k = 0; k < 4; k++) begin
      check("R11 no tick unprogrammed", {7'd0, tick}, 8'h00);
      @(negedge clk);
    end

    // R9: divide 3 gives period 4, first tick 3 cycles after write.
    do_reset();
    do_write(8'h03, 1'b1, 1'b0);
    tick_run("R9 divide 3", 3, 12);

    // R9: divide 0 ticks every cycle.
    do_reset();
    do_write(8'h00, 1'b1, 1'b0);
    check("R3 write of zero sets flag", rd_data, 8'h80);
    tick_run("R9 divide 0", 0, 5);

    // R10: change divide mid count.
    do_reset();
    do_write(8'h03, 1'b1, 1'b0);
    check("R10 pre tick k0", {7'd0, tick}, 8'h00);
    @(negedge clk);
    check("R10 pre tick k1", {7'd0, tick}, 8'h00);
    do_write(8'h05, 1'b1, 1'b0);
    tick_run("R10 restart divide 5", 5, 12);

    // R8: lock with divide 2 then attempt change; period stays 3.
    do_reset();
    do_write(8'h42, 1'b1, 1'b0);
    tick_run("R8 locked divide 2", 2, 6);
    do_write(8'h07, 1'b1, 1'b0);
    check("R5 locked readback", rd_data, 8'hC2);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule